// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Detection

This block receives asynchronous serial characters on a single input line and hands each one to a CPU-side holding register. A single clock drives the block. It sets the sample rate, and a two-bit setting chooses how many clocks make one bit period: 1, 16 or 64. At the 16 and 64 settings a falling edge counts as a start bit only if the line is still low at mid-bit. After that, each data bit, the optional parity bit and the stop bit are taken once at their mid-bit points. Data arrives least significant bit first, and a character carries 5 to 8 data bits.

Once a character is complete it is loaded into the holding register and a ready flag goes high. A one-cycle read strobe from the CPU clears the flag. If a character completes while the previous one is still unread, the old character is replaced and an overrun flag is set. Parity mismatches and low stop bits set sticky error flags. These flags, together with overrun, are cleared by an error-clear pulse.

The line can stay low through the stop-bit positions of two characters in a row. In that case a break output goes high, and it drops as soon as the line is high again.

Top module: `async_rx`

## Requirements
- R1: While `rst` is high at a clock edge, every output returns to zero: `rx_data`, `rx_ready`, `ovr_err`, `par_err`, `frm_err` and `brk_det`. The receiver then waits for a start bit.
- R2: `cfg_factor` selects the bit period in clocks: 2'b00 gives 1, 2'b01 gives 16, and 2'b10 or 2'b11 gives 64. A character sent at the selected rate is received intact at each of the three rates.
- R3: At the 16 and 64 rates, a low pulse on `rxd_i` that is high again before mid-bit is discarded and the receiver goes back to idle. No character is produced, and a following valid character is received correctly.
- R4: Data bits are received least significant bit first. `cfg_len` sets the character length: 2'b00 is 5 bits, 2'b01 is 6, 2'b10 is 7 and 2'b11 is 8. The received bits appear at the low end of `rx_data`, and the unused upper bits read as zero.
- R5: When `cfg_par_en` is high, one parity bit follows the data bits. `cfg_par_odd` set to 0 means even parity and set to 1 means odd parity. A mismatch sets `par_err`, and it stays set through later good characters.
- R6: A stop bit sampled low sets `frm_err`, which is sticky. The character is still delivered.
- R7: A one-cycle `err_clr` pulse clears `par_err`, `frm_err` and `ovr_err` at the next edge.
- R8: `rx_ready` goes high once a character completes. A one-cycle `rd_ack` clears it at the next edge.
- R9: If a character completes while `rx_ready` is high and no `rd_ack` arrives in that cycle, `ovr_err` is set. `rx_data` then holds the newer character.
- R10: `brk_det` goes high only after two consecutive characters both have a low stop bit with no high level on the line between them. A single low stop bit does not raise it.
- R11: Once the synchronised line reads high, `brk_det` goes low at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; sets the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Serial line, idle high |
| cfg_factor | input | 2 | Clocks per bit: 00=1, 01=16, 1x=64 |
| cfg_len | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_ack | input | 1 | CPU has read the holding register |
| err_clr | input | 1 | Clears the sticky error flags |
| rx_data | output | 8 | Holding register, right-aligned |
| rx_ready | output | 1 | Unread character present |
| ovr_err | output | 1 | Sticky overrun flag |
| par_err | output | 1 | Sticky parity-error flag |
| frm_err | output | 1 | Sticky framing-error flag |
| brk_det | output | 1 | Break condition on the line |

## Verification
Most internal faults in this block show up within one character time. If the bit-timing counter is off by one, the sample point moves toward a bit edge, and `rx_data` comes out shifted or corrupted on the next character. If the bit index or length decode is wrong, the upper bits of `rx_data` are wrong, which the 5-to-8 bit sweep exposes. A parity accumulator that is not cleared, or a break counter that is not reset, turns into a false `par_err` or `brk_det` on the very next character. A start validator that accepts glitches produces a spurious `rx_ready` about one frame after the glitch.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  parameter int RX_DW   = 8;
  parameter int MIN_LEN = 5;

  localparam logic [1:0] FAC_X1  = 2'b00;
  localparam logic [1:0] FAC_X16 = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rxd_i,
  output logic rxd_s
);

  logic [STAGES-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= '1;
    else     q <= {q[STAGES-2:0], rxd_i};
  end

  assign rxd_s = q[STAGES-1];

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import async_rx_pkg::*;
#(
  parameter int DW       = RX_DW,
  parameter int FAST_DIV = 16,
  parameter int SLOW_DIV = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rxd_s,
  input  logic [1:0]    cfg_factor,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  output logic          done,
  output logic [DW-1:0] f_data,
  output logic          f_perr,
  output logic          f_ferr
);

  localparam int CNT_W = $clog2(SLOW_DIV);
  localparam int IDX_W = $clog2(DW);

  rx_state_t        st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] div_m1;
  logic [CNT_W-1:0] half_m1;
  logic [IDX_W-1:0] bidx;
  logic [IDX_W-1:0] last_idx;
  logic [IDX_W-1:0] shamt;
  logic [DW-1:0]    sh;
  logic             par_acc;
  logic             perr_q;
  logic             fac_x1;

  // bit period and half period per rate setting
  always_comb begin
    fac_x1 = (cfg_factor == FAC_X1);
    case (cfg_factor)
      FAC_X1: begin
        div_m1  = '0;
        half_m1 = '0;
      end
      FAC_X16: begin
        div_m1  = CNT_W'(FAST_DIV - 1);
        half_m1 = CNT_W'(FAST_DIV / 2 - 1);
      end
      default: begin
        div_m1  = CNT_W'(SLOW_DIV - 1);
        half_m1 = CNT_W'(SLOW_DIV / 2 - 1);
      end
    endcase
    last_idx = IDX_W'(MIN_LEN - 1) + IDX_W'(cfg_len);
    shamt    = IDX_W'(DW - MIN_LEN) - IDX_W'(cfg_len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      sh      <= '0;
      par_acc <= 1'b0;
      perr_q  <= 1'b0;
      done    <= 1'b0;
      f_data  <= '0;
      f_perr  <= 1'b0;
      f_ferr  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (!rxd_s) begin
            bidx    <= '0;
            par_acc <= 1'b0;
            perr_q  <= 1'b0;
            if (fac_x1) begin
              st  <= ST_DATA;
              cnt <= '0;
            end else begin
              st  <= ST_START;
              cnt <= half_m1;
            end
          end
        end
        ST_START: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (rxd_s) begin
            st <= ST_IDLE;
          end else begin
            st  <= ST_DATA;
            cnt <= div_m1;
          end
        end
        ST_DATA: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            sh      <= {rxd_s, sh[DW-1:1]};
            par_acc <= par_acc ^ rxd_s;
            cnt     <= div_m1;
            if (bidx == last_idx) st <= cfg_par_en ? ST_PAR : ST_STOP;
            else                  bidx <= bidx + 1'b1;
          end
        end
        ST_PAR: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            perr_q <= ((par_acc ^ rxd_s) != cfg_par_odd);
            cnt    <= div_m1;
            st     <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            done   <= 1'b1;
            f_data <= sh >> shamt;
            f_perr <= perr_q;
            f_ferr <= !rxd_s;
            st     <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3
  glitch_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_START && cnt == '0 && rxd_s) |=> (st == ST_IDLE && !done));

  // R6
  stop_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_STOP && cnt == '0) |=> (done && f_ferr == !$past(rxd_s)));

endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          done,
  input  logic [DW-1:0] f_data,
  input  logic          f_perr,
  input  logic          f_ferr,
  input  logic          rd_ack,
  input  logic          err_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          ovr_err,
  output logic          par_err,
  output logic          frm_err
);

  logic lost;

  assign lost = done && rx_ready && !rd_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data  <= '0;
      rx_ready <= 1'b0;
      ovr_err  <= 1'b0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
    end else begin
      if (done) begin
        rx_data  <= f_data;
        rx_ready <= 1'b1;
      end else if (rd_ack) begin
        rx_ready <= 1'b0;
      end
      ovr_err <= (ovr_err && !err_clr) || lost;
      par_err <= (par_err && !err_clr) || (done && f_perr);
      frm_err <= (frm_err && !err_clr) || (done && f_ferr);
    end
  end

  // R8
  ready_set_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> rx_ready);

  // R8
  ready_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && !done) |=> !rx_ready);

  // R9
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (done && rx_ready && !rd_ack) |=> ovr_err);

  // R5
  perr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (par_err && !err_clr) |=> par_err);

  // R7
  err_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (err_clr && !done) |=> (!par_err && !frm_err && !ovr_err));

endmodule

// File: rtl/rx_break_det.sv
module rx_break_det #(
  parameter int BRK_FRAMES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rxd_s,
  input  logic done,
  input  logic stop_low,
  output logic brk_det
);

  localparam int CW = $clog2(BRK_FRAMES + 1);
  localparam logic [CW-1:0] BRK_M1 = CW'(BRK_FRAMES - 1);

  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= '0;
      brk_det <= 1'b0;
    end else if (rxd_s) begin
      run     <= '0;
      brk_det <= 1'b0;
    end else if (done) begin
      if (stop_low) begin
        if (run == BRK_M1) brk_det <= 1'b1;
        else               run <= run + 1'b1;
      end else begin
        run <= '0;
      end
    end
  end

  // R11
  brk_clr_chk: assert property (@(posedge clk) disable iff (rst)
    rxd_s |=> !brk_det);

  // R10
  brk_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(brk_det) |-> $past(done && stop_low));

endmodule

// File: rtl/async_rx.sv
module async_rx
  import async_rx_pkg::*;
#(
  parameter int DW          = RX_DW,
  parameter int FAST_DIV    = 16,
  parameter int SLOW_DIV    = 64,
  parameter int SYNC_STAGES = 2,
  parameter int BRK_FRAMES  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rxd_i,
  input  logic [1:0]    cfg_factor,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          rd_ack,
  input  logic          err_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          ovr_err,
  output logic          par_err,
  output logic          frm_err,
  output logic          brk_det
);

  logic          rxd_s;
  logic          done;
  logic [DW-1:0] f_data;
  logic          f_perr;
  logic          f_ferr;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .rxd_i (rxd_i),
    .rxd_s (rxd_s)
  );

  rx_frame_fsm #(.DW(DW), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .rxd_s       (rxd_s),
    .cfg_factor  (cfg_factor),
    .cfg_len     (cfg_len),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .done        (done),
    .f_data      (f_data),
    .f_perr      (f_perr),
    .f_ferr      (f_ferr)
  );

  rx_hold_reg #(.DW(DW)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .f_data   (f_data),
    .f_perr   (f_perr),
    .f_ferr   (f_ferr),
    .rd_ack   (rd_ack),
    .err_clr  (err_clr),
    .rx_data  (rx_data),
    .rx_ready (rx_ready),
    .ovr_err  (ovr_err),
    .par_err  (par_err),
    .frm_err  (frm_err)
  );

  rx_break_det #(.BRK_FRAMES(BRK_FRAMES)) u_brk (
    .clk      (clk),
    .rst      (rst),
    .rxd_s    (rxd_s),
    .done     (done),
    .stop_low (f_ferr),
    .brk_det  (brk_det)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!rx_ready && !ovr_err && !par_err && !frm_err && !brk_det && rx_data == '0));

endmodule

// File: tb/async_rx_tb.sv
module async_rx_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic [1:0] cfg_factor = 2'b00;
  logic [1:0] cfg_len = 2'b11;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       rd_ack = 1'b0;
  logic       err_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, ovr_err, par_err, frm_err, brk_det;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  async_rx u_dut (
    .clk         (clk),
    .rst         (rst),
    .rxd_i       (rxd),
    .cfg_factor  (cfg_factor),
    .cfg_len     (cfg_len),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .rd_ack      (rd_ack),
    .err_clr     (err_clr),
    .rx_data     (rx_data),
    .rx_ready    (rx_ready),
    .ovr_err     (ovr_err),
    .par_err     (par_err),
    .frm_err     (frm_err),
    .brk_det     (brk_det)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all stimulus changes 1 ns after a rising edge
  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic pulse_ack();
    rd_ack = 1'b1;
    @(posedge clk); #1;
    rd_ack = 1'b0;
  endtask

  task automatic pulse_clr();
    err_clr = 1'b1;
    @(posedge clk); #1;
    err_clr = 1'b0;
  endtask

  task automatic setup(input logic [1:0] fac, input logic [1:0] len, input logic pen, input logic podd);
    cfg_factor  = fac;
    cfg_len     = len;
    cfg_par_en  = pen;
    cfg_par_odd = podd;
  endtask

  function automatic int period(input logic [1:0] fac);
    return (fac == 2'b00) ? 1 : (fac == 2'b01) ? 16 : 64;
  endfunction

  task automatic send(input logic [7:0] d, input logic pflip, input logic stop_v, input int stop_slots);
    int f;
    int len;
    logic p;
    f   = period(cfg_factor);
    len = 5 + int'(cfg_len);
    p   = 1'b0;
    hold(1'b0, f);
    for (int i = 0; i < len; i++) begin
      hold(d[i], f);
      p = p ^ d[i];
    end
    if (cfg_par_en) hold(p ^ cfg_par_odd ^ pflip, f);
    hold(stop_v, stop_slots);
    hold(1'b1, f + 6);
  endtask

  function automatic logic [7:0] trim(input logic [7:0] d, input logic [1:0] len);
    return d & 8'((1 << (5 + int'(len))) - 1);
  endfunction

  task automatic t_reset();
    check("R1 ready", 32'(rx_ready), 32'd0);
    check("R1 data", 32'(rx_data), 32'd0);
    check("R1 flags", 32'({ovr_err, par_err, frm_err, brk_det}), 32'd0);
  endtask

  task automatic t_rates();
    logic [7:0] pat [3];
    pat[0] = 8'hA5; pat[1] = 8'h3C; pat[2] = 8'h96;
    for (int k = 0; k < 3; k++) begin
      setup(2'(k), 2'b11, 1'b0, 1'b0);
      send(pat[k], 1'b0, 1'b1, period(2'(k)));
      check("R2 data", 32'(rx_data), 32'(pat[k]));
      check("R8 ready set", 32'(rx_ready), 32'd1);
      pulse_ack();
      check("R8 ready clear", 32'(rx_ready), 32'd0);
    end
    // 2'b11 behaves as the 64 rate
    setup(2'b11, 2'b11, 1'b0, 1'b0);
    send(8'h4E, 1'b0, 1'b1, 64);
    check("R2 code 11", 32'(rx_data), 32'h4E);
    pulse_ack();
    check("R2 no flags", 32'({ovr_err, par_err, frm_err}), 32'd0);
  endtask

  task automatic t_lengths();
    for (int k = 0; k < 4; k++) begin
      setup(2'b01, 2'(k), 1'b0, 1'b0);
      send(8'hD7, 1'b0, 1'b1, 16);
      check("R4 length", 32'(rx_data), 32'(trim(8'hD7, 2'(k))));
      pulse_ack();
    end
  endtask

  task automatic t_parity();
    setup(2'b01, 2'b10, 1'b1, 1'b0);
    send(8'h5A, 1'b0, 1'b1, 16);
    check("R5 good even", 32'(par_err), 32'd0);
    check("R5 data", 32'(rx_data), 32'h5A);
    pulse_ack();
    setup(2'b01, 2'b10, 1'b1, 1'b1);
    send(8'h33, 1'b1, 1'b1, 16);
    check("R5 bad odd", 32'(par_err), 32'd1);
    pulse_ack();
    send(8'h21, 1'b0, 1'b1, 16);
    check("R5 sticky", 32'(par_err), 32'd1);
    check("R5 data after", 32'(rx_data), 32'h21);
    pulse_ack();
    pulse_clr();
    check("R7 parity clear", 32'(par_err), 32'd0);
  endtask

  task automatic t_framing();
    setup(2'b00, 2'b11, 1'b0, 1'b0);
    send(8'hC3, 1'b0, 1'b0, 1);
    check("R6 frame err", 32'(frm_err), 32'd1);
    check("R6 data kept", 32'(rx_data), 32'hC3);
    check("R10 single low stop", 32'(brk_det), 32'd0);
    pulse_ack();
    pulse_clr();
    check("R7 frame clear", 32'(frm_err), 32'd0);
  endtask

  task automatic t_overrun();
    setup(2'b00, 2'b11, 1'b0, 1'b0);
    send(8'h11, 1'b0, 1'b1, 1);
    send(8'h22, 1'b0, 1'b1, 1);
    check("R9 overrun", 32'(ovr_err), 32'd1);
    check("R9 newer data", 32'(rx_data), 32'h22);
    check("R9 ready", 32'(rx_ready), 32'd1);
    pulse_ack();
    check("R9 overrun sticky", 32'(ovr_err), 32'd1);
    pulse_clr();
    check("R7 overrun clear", 32'(ovr_err), 32'd0);
  endtask

  task automatic t_glitch();
    setup(2'b01, 2'b11, 1'b0, 1'b0);
    hold(1'b0, 4);
    hold(1'b1, 60);
    check("R3 glitch ignored", 32'(rx_ready), 32'd0);
    send(8'h69, 1'b0, 1'b1, 16);
    check("R3 next char", 32'(rx_data), 32'h69);
    check("R3 ready", 32'(rx_ready), 32'd1);
    pulse_ack();
  endtask

  task automatic t_break();
    setup(2'b01, 2'b11, 1'b0, 1'b0);
    hold(1'b0, 400);
    check("R10 break set", 32'(brk_det), 32'd1);
    hold(1'b1, 5);
    check("R11 break clear", 32'(brk_det), 32'd0);
    hold(1'b1, 200);
    pulse_ack();
    pulse_clr();
    check("R11 stays clear", 32'(brk_det), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    rst = 1'b0;
    hold(1'b1, 4);
    t_reset();
    t_rates();
    t_lengths();
    t_parity();
    t_framing();
    t_overrun();
    t_glitch();
    t_break();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule